// File: doc/BRIEF.md
# Zero-Turnaround Pipelined Synchronous SRAM

A single-port synchronous memory with 36-bit words, built around a two-stage request pipeline. Each command (address, operation type, lane enables) is captured on a rising edge. The data transfer that belongs to it happens a fixed two edges later, for reads and for writes alike. Because both directions share the same delay, a controller can issue any mix of reads and writes on consecutive edges and the shared data bus never needs an idle turnaround slot.

A command is either a load, which takes a fresh address from the pins, or an advance, which steps a two-bit beat counter inside a four-word group. The beat counter follows a linear or an XOR order, chosen by a static pin. Three chip selects gate new loads. A clock enable freezes the whole block, and an asynchronous output enable can silence the data drivers at any moment. The bidirectional bus is split into an input, an output and a drive-enable signal. The depth is kept small for simulation.

Top module: `zt_sram`

## Requirements
- R1: A command accepted on edge k has its data slot at edge k+2. A write takes `dq_in` at edge k+2. For a read, `dq_out` carries the word and `dq_oe` is high from edge k+2 until the next enabled edge.
- R2: Reads and writes can be issued on consecutive edges in any mix with no idle cycles. A read issued on the edge right after a write to the same address returns the newly written word.
- R3: The word has four 9-bit lanes, and lane i is bits 9i+8 down to 9i. On a write, `lane_we_n[i]` low stores lane i and `lane_we_n[i]` high leaves that lane's old contents unchanged.
- R4: `dq_oe` is high only in the data slot of a read while `out_en_n` is low. `out_en_n` acts on `dq_oe` at once, without a clock edge.
- R5: A load with the device deselected starts no access and drives nothing in its data slot. The device is selected only when `sel_a_n`=0, `sel_b`=1 and `sel_c_n`=0. Commands already in the pipeline still complete.
- R6: On an edge where `clk_en` is low, every input is ignored and all pipeline, burst and output state holds its value.
- R7: An advance (`adv_ld`=1) continues the current burst. It ignores `addr` and `rd_wr`, keeps the operation type of the load, and takes `lane_we_n` fresh on every beat.
- R8: Beat n of a burst (n = 0..3, wrapping) keeps the upper address bits of the load address. Its low two bits are (a+n) mod 4 when `burst_lin`=1 and a XOR n when `burst_lin`=0, where a is the low two bits of the load address.
- R9: A synchronous reset with `rst_n` low clears all pending commands, so `dq_oe` is low after the reset edge.
- R10: An advance that follows a deselected load stays idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en | input | 1 | Clock enable, high to operate |
| sel_a_n | input | 1 | Chip select, active low |
| sel_b | input | 1 | Chip select, active high |
| sel_c_n | input | 1 | Chip select, active low |
| rd_wr | input | 1 | Operation type on a load: 1 read, 0 write |
| lane_we_n | input | 4 | Per-lane write enables, active low |
| adv_ld | input | 1 | 0 loads a new address, 1 advances the burst |
| burst_lin | input | 1 | Burst order: 1 linear, 0 XOR |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| addr | input | 6 | Word address |
| dq_in | input | 36 | Write data from the bus |
| dq_out | output | 36 | Read data to the bus |
| dq_oe | output | 1 | Bus drive enable |

## Verification
The clocked properties assume that `clk_en` and the select pins are sampled as stable levels at each edge. They also assume that `burst_lin` is not changed in the middle of a burst. The stimulus sets every input at the falling edge and holds the burst order fixed across each group of advances. The stimulus also writes every address before any read, so no read in the reference model returns a location that was never written. The asynchronous enable is the only input that is moved between edges, and only around a read slot, to exercise R4.

// File: rtl/zt_pkg.sv
// Package zt_pkg
// Holds the fixed lane geometry and the burst beat-order function.
// Assumes a four-beat burst, so the beat index is two bits wide.
package zt_pkg;

    localparam int LANE_BITS = 9;

    // Low two address bits for beat n: linear adds, the other order XORs.
    function automatic logic [1:0] beat_lo(input logic [1:0] start,
                                           input logic [1:0] n,
                                           input logic       lin);
        return lin ? (start + n) : (start ^ n);
    endfunction

endpackage

// File: rtl/zt_burst_seq.sv
// Module zt_burst_seq
// Turns the load/advance pins into one command per edge. A load takes the
// address and type from the pins. An advance steps a two-bit beat counter
// and reuses the type and base of the load.
// Assumes burst_lin is static during a burst. ADDR_W must be at least 3.
module zt_burst_seq
    import zt_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              sel,
    input  logic              adv_ld,
    input  logic              rd_wr,
    input  logic              burst_lin,
    input  logic [ADDR_W-1:0] addr,
    output logic              op_valid,
    output logic              op_wr,
    output logic [ADDR_W-1:0] op_addr
);

    logic              act_q;
    logic              wr_q;
    logic [1:0]        cnt_q;
    logic [1:0]        cnt_nxt;
    logic [ADDR_W-1:0] base_q;

    assign cnt_nxt = cnt_q + 2'd1;

    // Pick the command for this edge: a fresh load or the next beat.
    always_comb begin
        if (!adv_ld) begin
            op_valid = sel;
            op_wr    = !rd_wr;
            op_addr  = addr;
        end else begin
            op_valid = act_q;
            op_wr    = wr_q;
            op_addr  = {base_q[ADDR_W-1:2], beat_lo(base_q[1:0], cnt_nxt, burst_lin)};
        end
    end

    // Hold the burst context: base, type, beat counter and activity.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q  <= 1'b0;
            wr_q   <= 1'b0;
            cnt_q  <= 2'd0;
            base_q <= '0;
        end else if (clk_en) begin
            if (!adv_ld) begin
                act_q  <= sel;
                wr_q   <= !rd_wr;
                cnt_q  <= 2'd0;
                base_q <= addr;
            end else if (act_q) begin
                cnt_q  <= cnt_nxt;
            end
        end
    end

    a_r7_advance_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && adv_ld && act_q) |=> (cnt_q == $past(cnt_q) + 2'd1));

    a_r8_load_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv_ld) |=> (cnt_q == 2'd0));

    a_r10_idle_stays: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv_ld && !sel) |=> (adv_ld -> !op_valid));

endmodule

// File: rtl/zt_pipe.sv
// Module zt_pipe
// A two-stage command delay. Stage 2 is the command whose data slot is the
// current edge. Every stage holds while the clock enable is low.
// Assumes the reset is synchronous and overrides the clock enable.
module zt_pipe #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clk_en,
    input  logic              op_valid,
    input  logic              op_wr,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic [LANES-1:0]  op_we_n,
    output logic              s2_valid,
    output logic              s2_wr,
    output logic [ADDR_W-1:0] s2_addr,
    output logic [LANES-1:0]  s2_we_n
);

    logic              s1_valid;
    logic              s1_wr;
    logic [ADDR_W-1:0] s1_addr;
    logic [LANES-1:0]  s1_we_n;

    // Shift the command one stage per enabled edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s2_valid <= 1'b0;
            s1_wr    <= 1'b0;
            s2_wr    <= 1'b0;
            s1_addr  <= '0;
            s2_addr  <= '0;
            s1_we_n  <= '1;
            s2_we_n  <= '1;
        end else if (clk_en) begin
            s1_valid <= op_valid;
            s1_wr    <= op_wr;
            s1_addr  <= op_addr;
            s1_we_n  <= op_we_n;
            s2_valid <= s1_valid;
            s2_wr    <= s1_wr;
            s2_addr  <= s1_addr;
            s2_we_n  <= s1_we_n;
        end
    end

    a_r1_stage_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && s1_valid) |=> s2_valid);

    a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_en |=> ($stable(s1_valid) && $stable(s2_valid) && $stable(s2_addr)));

endmodule

// File: rtl/zt_lane_mem.sv
// Module zt_lane_mem
// Word storage split into independent lane arrays. Each lane writes on its
// own enable, and reads are combinational.
// Assumes there is one write per edge and that the contents are not reset.
module zt_lane_mem #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                    clk,
    input  logic                    wr_en,
    input  logic [ADDR_W-1:0]       wr_addr,
    input  logic [LANES-1:0]        lane_we,
    input  logic [LANES*LANE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]       rd_addr,
    output logic [LANES*LANE_W-1:0] rd_data
);

    localparam int DEPTH = 1 << ADDR_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] store [DEPTH];

        // Write this lane when the word write and its lane enable are both set.
        always_ff @(posedge clk) begin
            if (wr_en && lane_we[g]) store[wr_addr] <= wr_data[g*LANE_W +: LANE_W];
        end

        assign rd_data[g*LANE_W +: LANE_W] = store[rd_addr];
    end

endmodule

// File: rtl/zt_sram.sv
// Module zt_sram
// Top of the zero-turnaround memory. It joins the burst sequencer, the
// two-stage pipe, the lane storage and the output register. Writes land and
// reads launch in the same data slot two edges after their command.
// Assumes out_en_n may change at any time. All other inputs are synchronous.
module zt_sram
    import zt_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clk_en,
    input  logic                       sel_a_n,
    input  logic                       sel_b,
    input  logic                       sel_c_n,
    input  logic                       rd_wr,
    input  logic [LANES-1:0]           lane_we_n,
    input  logic                       adv_ld,
    input  logic                       burst_lin,
    input  logic                       out_en_n,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [LANES*LANE_BITS-1:0] dq_in,
    output logic [LANES*LANE_BITS-1:0] dq_out,
    output logic                       dq_oe
);

    localparam int WORD_W = LANES * LANE_BITS;

    logic              sel;
    logic              op_valid;
    logic              op_wr;
    logic [ADDR_W-1:0] op_addr;
    logic              s2_valid;
    logic              s2_wr;
    logic [ADDR_W-1:0] s2_addr;
    logic [LANES-1:0]  s2_we_n;
    logic [WORD_W-1:0] rd_data;
    logic              out_valid;
    logic [WORD_W-1:0] out_q;
    logic              slot_wr;
    logic              slot_rd;

    assign sel     = !sel_a_n && sel_b && !sel_c_n;
    assign slot_wr = clk_en && s2_valid && s2_wr;
    assign slot_rd = s2_valid && !s2_wr;

    zt_burst_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .sel(sel),
        .adv_ld(adv_ld), .rd_wr(rd_wr), .burst_lin(burst_lin), .addr(addr),
        .op_valid(op_valid), .op_wr(op_wr), .op_addr(op_addr)
    );

    zt_pipe #(.ADDR_W(ADDR_W), .LANES(LANES)) u_pipe (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
        .op_valid(op_valid), .op_wr(op_wr), .op_addr(op_addr), .op_we_n(lane_we_n),
        .s2_valid(s2_valid), .s2_wr(s2_wr), .s2_addr(s2_addr), .s2_we_n(s2_we_n)
    );

    zt_lane_mem #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_BITS)) u_mem (
        .clk(clk), .wr_en(slot_wr), .wr_addr(s2_addr), .lane_we(~s2_we_n),
        .wr_data(dq_in), .rd_addr(s2_addr), .rd_data(rd_data)
    );

    // Capture read data in its slot and mark the bus as owned for one beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_q     <= '0;
        end else if (clk_en) begin
            out_valid <= slot_rd;
            if (slot_rd) out_q <= rd_data;
        end
    end

    assign dq_out = out_q;
    assign dq_oe  = out_valid && !out_en_n;

    a_r4_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && s2_valid && !s2_wr) |=> (dq_oe == !out_en_n));

    a_r1_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && s2_valid && s2_wr) |=> !dq_oe);

    a_r5_deselect_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en && !adv_ld && !sel) |=> !u_pipe.s1_valid);

endmodule

// File: tb/sim_zt_sram.sv
// Bench for zt_sram. A behavioural model (a plain array and a two-entry
// command list) predicts dq_oe and dq_out. Each cycle the model is updated
// at the rising edge and compared with the design at the falling edge.
module sim_zt_sram;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clk_en = 1'b1;
    logic        sel_a_n = 1'b0;
    logic        sel_b = 1'b1;
    logic        sel_c_n = 1'b0;
    logic        rd_wr = 1'b1;
    logic [3:0]  lane_we_n = 4'hF;
    logic        adv_ld = 1'b0;
    logic        burst_lin = 1'b1;
    logic        out_en_n = 1'b0;
    logic [5:0]  addr = '0;
    logic [35:0] dq_in = '0;
    logic [35:0] dq_out;
    logic        dq_oe;

    int    n_checks = 0;
    int    n_fails = 0;
    int    cyc_no = 0;
    bit    done = 1'b0;
    string cur_req = "R9";

    // reference model state
    logic [35:0] mem [64];
    bit          pv [2];
    bit          pw [2];
    logic [5:0]  pa [2];
    logic [3:0]  pb [2];
    bit          ev = 1'b0;
    logic [35:0] ed = '0;
    bit          bact = 1'b0;
    bit          bwr = 1'b0;
    logic [5:0]  bbase = '0;
    int          bn = 0;

    zt_sram u0 (
        .clk(clk), .rst_n(rst_n), .clk_en(clk_en),
        .sel_a_n(sel_a_n), .sel_b(sel_b), .sel_c_n(sel_c_n),
        .rd_wr(rd_wr), .lane_we_n(lane_we_n), .adv_ld(adv_ld),
        .burst_lin(burst_lin), .out_en_n(out_en_n), .addr(addr),
        .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
    );

    always #10 clk = ~clk;

    task automatic model_edge();
        bit         s;
        logic [1:0] lo;
        if (!rst_n) begin
            pv[0] = 0; pv[1] = 0; ev = 0; bact = 0;
        end else if (clk_en) begin
            if (pv[1] && pw[1]) begin
                for (int l = 0; l < 4; l++)
                    if (!pb[1][l]) mem[pa[1]][l*9 +: 9] = dq_in[l*9 +: 9];
                ev = 0;
            end else if (pv[1]) begin
                ed = mem[pa[1]];
                ev = 1;
            end else begin
                ev = 0;
            end
            pv[1] = pv[0]; pw[1] = pw[0]; pa[1] = pa[0]; pb[1] = pb[0];
            s = !sel_a_n && sel_b && !sel_c_n;
            if (!adv_ld) begin
                bact = s; bbase = addr; bn = 0; bwr = !rd_wr;
                pv[0] = s; pw[0] = !rd_wr; pa[0] = addr;
            end else if (bact) begin
                bn = (bn + 1) % 4;
                lo = burst_lin ? 2'(bbase[1:0] + 2'(bn)) : (bbase[1:0] ^ 2'(bn));
                pv[0] = 1; pw[0] = bwr; pa[0] = {bbase[5:2], lo};
            end else begin
                pv[0] = 0;
            end
            pb[0] = lane_we_n;
        end
    endtask

    task automatic compare();
        bit exp_oe;
        exp_oe = ev && !out_en_n;
        n_checks++;
        if (dq_oe !== exp_oe) begin
            n_fails++;
            $display("FAIL %s cycle %0d: dq_oe=%b expected %b", cur_req, cyc_no, dq_oe, exp_oe);
        end else if (exp_oe && dq_out !== ed) begin
            n_fails++;
            $display("FAIL %s cycle %0d: dq_out=%h expected %h", cur_req, cyc_no, dq_out, ed);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        model_edge();
        @(negedge clk);
        cyc_no++;
        compare();
        dq_in = 36'(cyc_no * 36'h9E3779B97) ^ 36'h5A5A5A5A5;
    endtask

    task automatic ld(input bit rd, input logic [5:0] a, input logic [3:0] be);
        adv_ld = 0; rd_wr = rd; addr = a; lane_we_n = be;
        cyc();
    endtask

    task automatic adv(input bit junk_rd, input logic [5:0] junk_a, input logic [3:0] be);
        adv_ld = 1; rd_wr = junk_rd; addr = junk_a; lane_we_n = be;
        cyc();
    endtask

    task automatic desel();
        adv_ld = 0; sel_b = 0; addr = 6'h3F; rd_wr = 1;
        cyc();
        sel_b = 1;
    endtask

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        @(negedge clk);
        // R9: reset clears everything in flight
        cur_req = "R9";
        repeat (3) cyc();
        rst_n = 1;
        // fill every address with full-lane writes (R1)
        cur_req = "R1";
        for (int i = 0; i < 64; i++) ld(0, 6'(i), 4'h0);
        ld(1, 6'd3, 4'hF);
        ld(1, 6'd40, 4'hF);
        desel(); desel(); desel();
        // R2: write then read of the same address on adjacent edges
        cur_req = "R2";
        for (int i = 0; i < 6; i++) begin
            ld(0, 6'(10 + i), 4'h0);
            ld(1, 6'(10 + i), 4'hF);
        end
        ld(1, 6'd11, 4'hF); ld(0, 6'd12, 4'h0); ld(1, 6'd12, 4'hF); ld(0, 6'd13, 4'h0);
        desel(); desel(); desel();
        // R3: partial lane writes keep the untouched lanes
        cur_req = "R3";
        ld(0, 6'd20, 4'b1010); ld(0, 6'd21, 4'b0101); ld(0, 6'd22, 4'b1110);
        ld(1, 6'd20, 4'h0); ld(1, 6'd21, 4'h0); ld(1, 6'd22, 4'h0);
        desel(); desel(); desel();
        // R5: deselect behind pending ops, they still complete
        cur_req = "R5";
        ld(1, 6'd20, 4'hF); ld(0, 6'd30, 4'h0); desel(); desel(); ld(1, 6'd30, 4'hF);
        desel(); desel(); desel();
        // R6: clock enable low in the middle of the pipe
        cur_req = "R6";
        ld(1, 6'd21, 4'hF); ld(0, 6'd31, 4'h0);
        clk_en = 0; rd_wr = 0; addr = 6'd5; lane_we_n = 4'h0;
        cyc(); cyc();
        clk_en = 1;
        ld(1, 6'd31, 4'hF); desel();
        clk_en = 0; cyc(); cyc(); clk_en = 1;
        desel(); desel(); desel();
        // R7, R8: linear write burst from 6, then XOR read burst from 5
        cur_req = "R7";
        burst_lin = 1;
        ld(0, 6'd6, 4'h0); adv(1, 6'd50, 4'h0); adv(1, 6'd51, 4'b0011); adv(1, 6'd52, 4'h0);
        cur_req = "R8";
        burst_lin = 0;
        ld(1, 6'd5, 4'hF); adv(0, 6'd60, 4'h0); adv(0, 6'd61, 4'h0); adv(0, 6'd62, 4'h0);
        adv(0, 6'd63, 4'h0);
        burst_lin = 1;
        ld(1, 6'd7, 4'hF); adv(0, 6'd0, 4'h0); adv(0, 6'd0, 4'h0); adv(0, 6'd0, 4'h0);
        desel(); desel(); desel();
        // R10: advance after a deselected load does nothing
        cur_req = "R10";
        desel(); adv(0, 6'd7, 4'h0); adv(1, 6'd7, 4'h0); desel();
        ld(1, 6'd7, 4'hF); desel(); desel(); desel();
        // R4: asynchronous output enable inside a read slot
        cur_req = "R4";
        ld(1, 6'd8, 4'hF); desel(); desel();
        #2 out_en_n = 1;
        #1 n_checks++;
        if (dq_oe !== 1'b0) begin
            n_fails++;
            $display("FAIL R4: dq_oe=%b expected 0 with output enable off", dq_oe);
        end
        out_en_n = 0;
        #1 n_checks++;
        if (dq_oe !== 1'b1) begin
            n_fails++;
            $display("FAIL R4: dq_oe=%b expected 1 with output enable back on", dq_oe);
        end
        out_en_n = 1; ld(1, 6'd9, 4'hF); desel(); desel();
        out_en_n = 0; desel(); desel();
        // R9 again: reset with a read in flight
        cur_req = "R9";
        ld(1, 6'd8, 4'hF); rst_n = 0; cyc(); rst_n = 1; desel(); desel(); desel();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_checks, n_fails);
        $finish;
    end

endmodule